// File: doc/BRIEF.md
# Four-Mode Serial Peripheral Master

This block is a single-lane SPI master that moves an arbitrary number of bits in one operation. While it shifts bits out on the data-out pin, it captures the same number of bits from the data-in pin. It supports all four combinations of clock polarity and clock phase. The speed is set by a half-period divider. A controller starts an operation with a one-cycle strobe. With that strobe it supplies the bit count, the mode, two select-window flags, the divider and two lane-disable options.

Transmit bytes are pulled through a byte-wide valid/ready handshake. If no byte is offered when one is needed, zeros are sent in its place. Received bytes come back on a byte-wide output with a one-cycle valid strobe. When the bit count is not a multiple of eight, the last byte is left-justified.

The open flag and the close flag decide whether chip select is asserted at the start of an operation and released at its end. A single select window can therefore span several operations. A write-only or read-only wiring is handled by disabling the data-out lane or the data-in lane.

Top module: `spim_engine`

## Requirements
- R1: Bits go out on `spi_mosi` most-significant bit first. A new transmit byte is taken every eight bits: `tx_ready` is high for one cycle, and the byte on `tx_byte` is used if `tx_valid` is high in that cycle.
- R2: The idle level of `spi_sclk` equals `mode_cpol` (0 gives a low idle, 1 a high idle). The clock is already at idle when chip select becomes active, and it is back at idle after the last bit.
- R3: With `mode_cpha`=0, `spi_mosi` changes only while the clock is idle. `spi_miso` is sampled on the idle-to-active edge.
- R4: With `mode_cpha`=1, `spi_mosi` changes on the same cycle that the clock leaves idle. `spi_miso` is sampled on the active-to-idle edge.
- R5: Each of the two clock phases of a bit lasts `half_div`+1 system cycles. A divider of 0 gives one cycle per phase.
- R6: `rx_valid` pulses once after every eighth sampled bit, with the byte MSB-first on `rx_byte`. A final partial byte of m bits is presented once, after the last bit, with its bits in the top m positions and zeros below.
- R7: If `tx_valid` is low when a byte is taken, zeros are shifted out for that byte.
- R8: With `rx_disable`=1, zeros replace `spi_miso` in every received byte. With `tx_disable`=1, `spi_mosi` does not change during the operation.
- R9: A start with both `tx_disable` and `rx_disable` set is rejected. `cfg_err` pulses for one cycle, and no operation or clock edge follows.
- R10: Chip select is asserted at the start only if `sel_begin`=1, and released at the end only if `sel_end`=1, so a window can span operations. Parameter `CS_ACTIVE_HIGH`=0 (the default) makes `spi_cs` active-low.
- R11: `busy` is high from the cycle after an accepted start until the last phase and any select release are done. Then `done` pulses for exactly one cycle, with `busy` low.
- R12: A bit count of 0 completes with a `done` pulse, no clock edge and no received byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle strobe that latches the settings below when idle |
| xfer_bits | input | CNT_W | Number of bits in the operation |
| mode_cpol | input | 1 | Idle clock level |
| mode_cpha | input | 1 | Sampling edge select |
| sel_begin | input | 1 | Assert chip select at the start |
| sel_end | input | 1 | Release chip select at the end |
| half_div | input | DIV_W | Half-period length minus one, in system cycles |
| tx_disable | input | 1 | Leave the data-out pin untouched |
| rx_disable | input | 1 | Shift zeros in instead of the data-in pin |
| tx_byte | input | DATA_W | Transmit byte |
| tx_valid | input | 1 | Transmit byte is offered |
| tx_ready | output | 1 | Transmit byte is taken this cycle |
| rx_byte | output | DATA_W | Received byte |
| rx_valid | output | 1 | Received byte strobe |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | 1 | Chip select |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| cfg_err | output | 1 | One-cycle pulse for a rejected start |

## Verification
The bench acts as a slave that watches the pins. It records what `spi_mosi` holds at every sampling edge, and it advances its own `spi_miso` pattern just after each sampling edge. A mode mistake therefore shows up as shifted or swapped bits in both directions.

The bench targets these corner cases and the failure each one would expose:
- Partial final bytes (12 and 3 bits). A design that does not left-justify would return the bits right-aligned.
- A divider of zero. An off-by-one divider would stretch or merge phases.
- A zero bit count. A design that loops unconditionally would emit spurious clock edges or a stray byte.
- Mode changes between operations. A design that moves the clock after chip select goes active would be caught at the select edge.
- A select window held across two operations. A design that ignores the flags would drop and re-assert chip select between them.

// File: rtl/spim_pkg.sv
// Shared types for the serial master: controller states and the settings
// captured when an operation is accepted.
package spim_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,   // waiting for start
        ST_PARK = 3'd1,   // clock moved to idle level
        ST_LEAD = 3'd2,   // select settling, one half-period
        ST_PH_A = 3'd3,   // first half of a bit, ends with the sample
        ST_PH_B = 3'd4,   // second half of a bit
        ST_TAIL = 3'd5,   // clock idle, optional select release
        ST_FIN  = 3'd6    // completion pulse
    } spim_state_e;

    typedef struct packed {
        logic cpol;
        logic cpha;
        logic open_sel;
        logic close_sel;
        logic tx_off;
        logic rx_off;
    } spim_cfg_t;

endpackage

// File: rtl/spim_halfper_timer.sv
// Half-period timer. A load sets the count to the divider value, and the
// count runs down to zero, so a phase lasts load_val+1 cycles. It assumes
// the controller reloads it at the start of every phase.
module spim_halfper_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] load_val,
    output logic             expire
);

    logic [DIV_W-1:0] cnt_q;

    // Count down from the loaded value and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expire = (cnt_q == '0);

endmodule

// File: rtl/spim_tx_shifter.sv
// Transmit shifter. It holds the current byte with the current bit at the
// top. A load takes a new byte, or zeros when none is offered. A shift
// moves to the next bit. The output pin is frozen while tx_off is high.
module spim_tx_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic              tx_off,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              mosi
);

    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] sh_q;
    logic [DATA_W-1:0] fresh;

    // Pick the offered byte, or zeros when the source is empty.
    always_comb begin
        fresh = in_valid ? in_data : '0;
    end

    // Byte register: load a new byte, or move the next bit to the top.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sh_q <= '0;
        else if (load)
            sh_q <= fresh;
        else if (shift)
            sh_q <= {sh_q[MSB-1:0], 1'b0};
    end

    // Output pin: follows the top bit unless the lane is disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mosi <= 1'b0;
        else if (!tx_off) begin
            if (load)
                mosi <= fresh[MSB];
            else if (shift)
                mosi <= sh_q[MSB-1];
        end
    end

    // The lane stays frozen whenever it is disabled.
    AST_TXOFF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        tx_off |=> $stable(mosi)); // R8

endmodule

// File: rtl/spim_rx_gather.sv
// Receive assembler. It collects sampled bits MSB-first. After every
// DATA_W-th bit it presents the byte. On the last bit of an operation it
// presents the partial byte left-justified. Assumes DATA_W is a power of two.
module spim_rx_gather #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              sample,
    input  logic              bit_in,
    input  logic              last,
    output logic [DATA_W-1:0] data,
    output logic              valid
);

    localparam int POS_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [POS_W-1:0] TOP = POS_W'(DATA_W - 1);

    logic [DATA_W-1:0] sh_q;
    logic [POS_W-1:0]  cnt_q;
    logic [DATA_W-1:0] grown;

    // Accumulator with the new bit appended at the bottom.
    always_comb begin
        grown = {sh_q[DATA_W-2:0], bit_in};
    end

    // Gather bits; emit a full byte or the left-justified final byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
            data  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (clear) begin
                sh_q  <= '0;
                cnt_q <= '0;
            end else if (sample) begin
                if (cnt_q == TOP) begin
                    data  <= grown;
                    valid <= 1'b1;
                    cnt_q <= '0;
                end else if (last) begin
                    data  <= grown << (TOP - cnt_q);
                    valid <= 1'b1;
                    cnt_q <= '0;
                end else begin
                    sh_q  <= grown;
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // A byte appears only in the cycle after a sample.
    AST_RX_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $past(sample)); // R6

endmodule

// File: rtl/spim_engine.sv
// Serial master controller. An accepted start latches the settings. The
// clock is parked at its idle level, chip select is optionally opened, and
// each bit is run as two timed phases. MISO is sampled at the end of the
// first phase in both phase modes; only the clock levels of the phases
// differ. The inputs are assumed synchronous to clk, and start is ignored
// while an operation runs.
module spim_engine
    import spim_pkg::*;
#(
    parameter int CNT_W          = 16,
    parameter int DIV_W          = 8,
    parameter int DATA_W         = 8,
    parameter bit CS_ACTIVE_HIGH = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  xfer_bits,
    input  logic              mode_cpol,
    input  logic              mode_cpha,
    input  logic              sel_begin,
    input  logic              sel_end,
    input  logic [DIV_W-1:0]  half_div,
    input  logic              tx_disable,
    input  logic              rx_disable,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_cs,
    output logic              busy,
    output logic              done,
    output logic              cfg_err
);

    localparam int POS_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [POS_W-1:0] POS_TOP = POS_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] ONE_BIT = CNT_W'(1);

    spim_state_e      state_q, state_d;
    spim_cfg_t        cfg_q;
    logic [CNT_W-1:0] left_q;
    logic [DIV_W-1:0] div_q;
    logic [POS_W-1:0] pos_q;
    logic             sclk_q, cs_act_q, err_q;

    logic accept, bad_cfg, phase_end;
    logic lead_end, a_end, b_end, enter_a;
    logic load_byte, shift_bit, last_bit, tmr_load;

    // Event decode for the controller.
    always_comb begin
        bad_cfg   = tx_disable && rx_disable;
        accept    = start && (state_q == ST_IDLE);
        lead_end  = (state_q == ST_LEAD) && phase_end;
        a_end     = (state_q == ST_PH_A) && phase_end;
        b_end     = (state_q == ST_PH_B) && phase_end;
        enter_a   = (lead_end || b_end) && (left_q != '0);
        load_byte = enter_a && (pos_q == '0);
        shift_bit = enter_a && (pos_q != '0);
        last_bit  = a_end && (left_q == ONE_BIT);
        tmr_load  = (state_q == ST_PARK) || enter_a || a_end;
    end

    // Next-state logic of the operation sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept && !bad_cfg) state_d = ST_PARK;
            ST_PARK: state_d = ST_LEAD;
            ST_LEAD: if (phase_end) state_d = (left_q != '0) ? ST_PH_A : ST_TAIL;
            ST_PH_A: if (phase_end) state_d = ST_PH_B;
            ST_PH_B: if (phase_end) state_d = (left_q != '0) ? ST_PH_A : ST_TAIL;
            ST_TAIL: state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Latch the operation settings when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            div_q <= '0;
        end else if (accept && !bad_cfg) begin
            cfg_q <= '{cpol: mode_cpol, cpha: mode_cpha, open_sel: sel_begin,
                       close_sel: sel_end, tx_off: tx_disable, rx_off: rx_disable};
            div_q <= half_div;
        end
    end

    // Bits remaining and position inside the current byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
            pos_q  <= '0;
        end else if (accept && !bad_cfg) begin
            left_q <= xfer_bits;
            pos_q  <= '0;
        end else if (a_end) begin
            left_q <= left_q - 1'b1;
            pos_q  <= (pos_q == POS_TOP) ? '0 : pos_q + 1'b1;
        end
    end

    // Clock level per phase: idle before and after, mode-dependent inside.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sclk_q <= 1'b0;
        else if (accept && !bad_cfg)
            sclk_q <= mode_cpol;
        else if (enter_a)
            sclk_q <= cfg_q.cpol ^ cfg_q.cpha;
        else if (a_end)
            sclk_q <= cfg_q.cpol ^ ~cfg_q.cpha;
        else if (b_end)
            sclk_q <= cfg_q.cpol;
    end

    // Select window: opened after parking, closed in the tail if requested.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cs_act_q <= 1'b0;
        else if (state_q == ST_PARK && cfg_q.open_sel)
            cs_act_q <= 1'b1;
        else if (state_q == ST_TAIL && cfg_q.close_sel)
            cs_act_q <= 1'b0;
    end

    // One-cycle pulse for a rejected configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= accept && bad_cfg;
    end

    spim_halfper_timer #(.DIV_W(DIV_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (div_q),
        .expire   (phase_end)
    );

    spim_tx_shifter #(.DATA_W(DATA_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_byte),
        .shift    (shift_bit),
        .tx_off   (cfg_q.tx_off),
        .in_valid (tx_valid && !cfg_q.tx_off),
        .in_data  (tx_byte),
        .mosi     (spi_mosi)
    );

    spim_rx_gather #(.DATA_W(DATA_W)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (accept),
        .sample (a_end),
        .bit_in (cfg_q.rx_off ? 1'b0 : spi_miso),
        .last   (last_bit),
        .data   (rx_byte),
        .valid  (rx_valid)
    );

    generate
        if (CS_ACTIVE_HIGH) begin : g_cs_high
            assign spi_cs = cs_act_q;
        end else begin : g_cs_low
            assign spi_cs = ~cs_act_q;
        end
    endgenerate

    assign tx_ready = load_byte && !cfg_q.tx_off;
    assign spi_sclk = sclk_q;
    assign busy     = (state_q != ST_IDLE) && (state_q != ST_FIN);
    assign done     = (state_q == ST_FIN);
    assign cfg_err  = err_q;

    AST_CLK_IDLE_AT_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_act_q) |-> (spi_sclk == cfg_q.cpol)); // R2
    AST_CLK_IDLE_IN_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TAIL) |-> (spi_sclk == cfg_q.cpol)); // R2
    AST_SELECT_CLOSE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_act_q) |-> ($past(state_q) == ST_TAIL)); // R10
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R11
    AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !busy); // R9
    AST_RXOFF_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && cfg_q.rx_off) |-> (rx_byte == '0)); // R8
    AST_FEED_IN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |=> (state_q == ST_PH_A)); // R1

endmodule

// File: tb/spim_engine_bench.sv
module spim_engine_bench;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n = 1'b0, start = 1'b0;
    logic [15:0] bits = '0;
    logic        cpol = 0, cpha = 0, beg = 0, fin = 0, txoff = 0, rxoff = 0;
    logic [7:0]  div = '0, tx_byte = '0;
    logic        tx_valid = 1'b0, miso = 1'b0;
    wire         tx_ready, rx_valid, sclk, mosi, cs, busy, done, cfg_err;
    wire  [7:0]  rx_byte;

    spim_engine u_spim_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .xfer_bits(bits),
        .mode_cpol(cpol), .mode_cpha(cpha), .sel_begin(beg), .sel_end(fin),
        .half_div(div), .tx_disable(txoff), .rx_disable(rxoff),
        .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .spi_sclk(sclk),
        .spi_mosi(mosi), .spi_miso(miso), .spi_cs(cs), .busy(busy),
        .done(done), .cfg_err(cfg_err));

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic [7:0] sl [0:7];
    logic [7:0] txb [0:7];
    logic mosi_bits [0:63];
    logic [7:0] rxbuf [0:7];
    int  m_edges, m_nsamp, nrx, gap_min, gap_max, last_edge;
    int  idle_bad, setup_bad, cs_drops, cs_rises, mosi_chg, err_seen, tx_idx;
    bit  m_cpol, m_cpha, give_tx, tx_take, done_busy;
    bit  p_cs = 0, p_sclk = 0, p_mosi = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Pin monitor, slave data source and transmit feeder.
    always @(negedge clk) begin
        bit cs_on, samp;
        cyc++;
        cs_on = (cs === 1'b0);
        if (cs_on && !p_cs) begin
            cs_rises++;
            if (sclk !== m_cpol) idle_bad++;
        end
        if (!cs_on && p_cs) cs_drops++;
        if (cs_on && p_cs && sclk !== p_sclk) begin
            m_edges++;
            if (last_edge >= 0) begin
                if (cyc - last_edge < gap_min) gap_min = cyc - last_edge;
                if (cyc - last_edge > gap_max) gap_max = cyc - last_edge;
            end
            last_edge = cyc;
            samp = m_cpha ? (sclk === m_cpol) : (p_sclk === m_cpol);
            if (samp) begin
                if (m_nsamp < 64) mosi_bits[m_nsamp] = mosi;
                m_nsamp++;
            end
        end
        if (cs_on && p_cs && mosi !== p_mosi) begin
            mosi_chg++;
            if (!m_cpha && sclk !== m_cpol) setup_bad++;
            if (m_cpha && !(sclk !== p_sclk && p_sclk === m_cpol)) setup_bad++;
        end
        if (rx_valid) begin
            if (nrx < 8) rxbuf[nrx] = rx_byte;
            nrx++;
        end
        if (cfg_err) err_seen++;
        miso = (m_nsamp < 64) ? sl[m_nsamp/8][7-(m_nsamp%8)] : 1'b0;
        if (tx_take) tx_idx++;
        tx_valid = give_tx && (tx_idx < 8);
        tx_byte  = (tx_idx < 8) ? txb[tx_idx] : 8'h00;
        tx_take  = tx_ready && tx_valid;
        p_cs = cs_on; p_sclk = sclk; p_mosi = mosi;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic run_xfer(input int b, input bit pol, input bit pha, input bit bg,
                            input bit en, input int dv, input bit toff, input bit roff,
                            input bit gtx, input bit wait_done);
        int n;
        @(posedge clk); #1;
        m_cpol = pol; m_cpha = pha; m_edges = 0; m_nsamp = 0; nrx = 0;
        gap_min = 1000; gap_max = 0; last_edge = -1; idle_bad = 0; setup_bad = 0;
        cs_drops = 0; cs_rises = 0; mosi_chg = 0; err_seen = 0; tx_idx = 0;
        tx_take = 0; give_tx = gtx;
        bits = 16'(b); cpol = pol; cpha = pha; beg = bg; fin = en; div = 8'(dv);
        txoff = toff; rxoff = roff; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        n = 0;
        if (wait_done) begin
            while (done !== 1'b1 && n < 20000) begin @(negedge clk); n++; end
            chk(done === 1'b1, "R11", "done reached", int'(done), 1);
            done_busy = busy;
            @(negedge clk);
            chk(done === 1'b0, "R11", "done one cycle", int'(done), 0);
        end else begin
            repeat (20) @(negedge clk);
        end
    endtask

    task automatic check_xfer(input string req, input int b, input int dv,
                              input bit gtx, input bit roff, input bit chk_tx);
        int nb, m;
        logic [7:0] e;
        nb = (b + 7) / 8;
        chk(nrx == nb, req, "rx byte count", nrx, nb);
        for (int i = 0; i < nb && i < 8; i++) begin
            m = (i == nb - 1 && b % 8 != 0) ? b % 8 : 8;
            e = roff ? 8'h00 : (sl[i] & (8'hFF << (8 - m)));
            chk(rxbuf[i] === e, req, $sformatf("rx byte %0d", i), int'(rxbuf[i]), int'(e));
        end
        chk(m_nsamp == b, req, "sample edges", m_nsamp, b);
        chk(m_edges == 2 * b, "R2", "clock edges", m_edges, 2 * b);
        if (chk_tx) begin
            int bad = 0;
            for (int k = 0; k < b && k < 64; k++)
                if (mosi_bits[k] !== (gtx ? txb[k/8][7-(k%8)] : 1'b0)) bad++;
            chk(bad == 0, req, "mosi bit mismatches", bad, 0);
        end
        if (b > 0) begin
            chk(gap_min == dv + 1 && gap_max == dv + 1, "R5", "half-period min/max",
                gap_min * 100 + gap_max, (dv + 1) * 101);
        end
        chk(idle_bad == 0, "R2", "clock not idle at select", idle_bad, 0);
        chk(setup_bad == 0, m_cpha ? "R4" : "R3", "mosi change timing", setup_bad, 0);
        chk(done_busy == 1'b0, "R11", "busy at done", int'(done_busy), 0);
    endtask

    task automatic t_reset();
        chk(cs === 1'b1, "R10", "reset select inactive", int'(cs), 1);
        chk(busy === 1'b0 && done === 1'b0, "R11", "reset busy/done", int'({busy, done}), 0);
        chk(sclk === 1'b0 && rx_valid === 1'b0, "R2", "reset clock/rx", int'({sclk, rx_valid}), 0);
    endtask

    task automatic t_modes();
        for (int md = 0; md < 4; md++) begin
            run_xfer(16, md[1], md[0], 1, 1, 1, 0, 0, 1, 1);
            check_xfer("R1", 16, 1, 1, 0, 1);
            chk(cs === 1'b1, "R10", "select released", int'(cs), 1);
            chk(sclk === md[1], "R2", "idle level after", int'(sclk), md[1]);
        end
    endtask

    task automatic t_partial();
        run_xfer(12, 0, 0, 1, 1, 0, 0, 0, 1, 1);
        check_xfer("R6", 12, 0, 1, 0, 1);
        run_xfer(3, 1, 1, 1, 1, 2, 0, 0, 1, 1);
        check_xfer("R6", 3, 2, 1, 0, 1);
    endtask

    task automatic t_divider();
        run_xfer(8, 0, 1, 1, 1, 3, 0, 0, 1, 1);
        check_xfer("R5", 8, 3, 1, 0, 1);
        run_xfer(8, 1, 0, 1, 1, 0, 0, 0, 1, 1);
        check_xfer("R5", 8, 0, 1, 0, 1);
    endtask

    task automatic t_notx();
        run_xfer(16, 0, 0, 1, 1, 1, 0, 0, 0, 1);
        check_xfer("R7", 16, 1, 0, 0, 1);
    endtask

    task automatic t_lane_off();
        run_xfer(16, 0, 0, 1, 1, 0, 0, 0, 1, 1);   // leaves mosi at last bit of 0x3C (0)
        run_xfer(16, 0, 1, 1, 1, 1, 1, 0, 1, 1);
        chk(mosi_chg == 0, "R8", "mosi changes with tx off", mosi_chg, 0);
        check_xfer("R8", 16, 1, 1, 0, 0);
        run_xfer(16, 1, 0, 1, 1, 1, 0, 1, 1, 1);
        check_xfer("R8", 16, 1, 1, 1, 1);
    endtask

    task automatic t_both_off();
        run_xfer(8, 0, 0, 1, 1, 0, 1, 1, 1, 0);
        chk(err_seen == 1, "R9", "cfg_err pulses", err_seen, 1);
        chk(m_edges == 0 && cs_rises == 0, "R9", "no activity", m_edges + cs_rises, 0);
        chk(busy === 1'b0, "R9", "not busy", int'(busy), 0);
    endtask

    task automatic t_zero();
        run_xfer(0, 0, 0, 1, 1, 0, 0, 0, 1, 1);
        chk(m_edges == 0 && nrx == 0, "R12", "zero bits activity", m_edges * 10 + nrx, 0);
        chk(cs_rises == 1 && cs_drops == 1, "R12", "zero bits select", cs_rises * 10 + cs_drops, 11);
    endtask

    task automatic t_hold();
        run_xfer(8, 1, 1, 1, 0, 1, 0, 0, 1, 1);
        check_xfer("R10", 8, 1, 1, 0, 1);
        chk(cs === 1'b0, "R10", "select held after first", int'(cs), 0);
        run_xfer(8, 1, 1, 0, 1, 1, 0, 0, 1, 1);
        check_xfer("R10", 8, 1, 1, 0, 1);
        chk(cs_rises == 0 && cs_drops == 1, "R10", "single window", cs_rises * 10 + cs_drops, 1);
        run_xfer(8, 0, 0, 0, 0, 0, 0, 0, 1, 1);
        chk(cs_rises == 0 && cs === 1'b1, "R10", "no select without begin", cs_rises, 0);
    endtask

    initial begin
        sl[0] = 8'hC6; sl[1] = 8'h5A; sl[2] = 8'h93; sl[3] = 8'h0F;
        sl[4] = 8'hE1; sl[5] = 8'h2D; sl[6] = 8'h78; sl[7] = 8'hB4;
        txb[0] = 8'hA5; txb[1] = 8'h3C; txb[2] = 8'h81; txb[3] = 8'h7E;
        txb[4] = 8'h12; txb[5] = 8'h34; txb[6] = 8'h56; txb[7] = 8'h78;
        m_nsamp = 0; last_edge = -1;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_modes();
        t_partial();
        t_divider();
        t_notx();
        t_lane_off();
        t_both_off();
        t_zero();
        t_hold();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule